// File: doc/BRIEF.md
# Conditional-Write Attention and Interrupt Controller

This block gathers hardware events into five attention registers, each with its own enable (notify) register, and reduces them through two masking levels to one interrupt line. A host reaches every register over a byte-wide control bus with single-cycle read and write strobes. The attention registers cover state, no-space, service, request and indicate events. A master attention register has one derived bit per attention register. A master notify register chooses which of those bits may raise the interrupt.

Attention bits are guarded by a read-compare-write handshake. Reading any attention register copies its value into one shared compare register. A later write to an attention register replaces only the bits whose current value still equals the compare register. A bit that hardware set after the host read no longer matches, so the write cannot clear it. Two bits of the service register mark idle helper operations. When a host write clears one of them, the block issues a start pulse for that operation, and hardware sets the bit again when the operation completes.

Top module: `attn_irq_ctrl`

## Requirements
- R1: After reset, the attention registers hold: state 0x07, no-space 0x00, service 0x03, request 0x00, indicate 0x00. All notify registers, the master notify register and the compare register hold 0. The irq and op_start outputs are low.
- R2: A read of an attention register loads the value read into the compare register. A read of any other address leaves the compare register unchanged.
- R3: A write to an attention register stores a data bit only where the register bit equals the compare bit. Every other bit keeps its value, so an event that lands between the read and the write survives.
- R4: A 1 on an event input sets the matching attention bit (register i uses evt_set bits 8i+7..8i). The set wins over a write to that register in the same cycle.
- R5: Notify registers are plain 8-bit read/write registers. The master notify register stores 5 bits and reads back zero in bits 7..5.
- R6: Master attention bit i is the OR of (attention i AND notify i), with i = 0 state, 1 no-space, 2 service, 3 request, 4 indicate. Both the master attention and compare addresses are read-only, and writes to them have no effect.
- R7: irq is a registered level equal to the OR of (master attention AND master notify), one cycle late.
- R8: op_start bit j (j = 0, 1) pulses for one cycle after a write that takes service bit j from 1 to 0. It stays low when the bit was already 0 or was held by a same-cycle event.
- R9: The address map is: 0 master attention, 1 master notify, 2..6 attention registers 0..4, 7 compare, 8..12 notify registers 0..4. bus_rdata shows the addressed value in the cycle after a read strobe. It is 0 in other cycles and for unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr_i | input | 4 | Register address |
| bus_wr_i | input | 1 | Single-cycle write strobe |
| bus_rd_i | input | 1 | Single-cycle read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| evt_set_i | input | 40 | Event set pulses, 8 per attention register |
| op_start_o | output | 2 | Start pulses for the two helper operations |
| irq_o | output | 1 | Interrupt level, active high |

## Verification
The bench targets the race the handshake exists for: an event that arrives after a read and before a write of 0. A design that compares the write against the data instead of against the stored register would drop that event. It also drives an event and a clearing write in the same cycle. Here a design with the wrong priority loses the bit, and a design that decides op_start from the data alone fires a start pulse anyway. Writes to the read-only master and compare addresses must leave them untouched. The irq output must lag by exactly one cycle when the master notify register changes. Long random runs that mix reads, writes and events check whether a design loads the compare register on notify reads.

// File: rtl/attn_pkg.sv
package attn_pkg;
  localparam int DW   = 8;
  localparam int NREG = 5;
  localparam int AW   = 4;
  localparam int NOP  = 2;

  localparam int IDX_STATE = 0;
  localparam int IDX_SVC   = 2;

  // Reset contents of attention register idx: stop bits for state,
  // idle completion bits for service, zero elsewhere.
  function automatic int att_rst_val(input int idx, input int nop);
    if (idx == IDX_STATE) return 32'h07;
    if (idx == IDX_SVC)   return (1 << nop) - 1;
    return 0;
  endfunction
endpackage

// File: rtl/attn_bank.sv
module attn_bank #(
  parameter int            DW      = 8,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          att_we,
  input  logic          ntf_we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] cmp,
  input  logic [DW-1:0] evt,
  output logic [DW-1:0] att_q,
  output logic [DW-1:0] ntf_q,
  output logic          mar_bit
);
  logic [DW-1:0] match;
  logic [DW-1:0] att_d;
  logic          att_en;

  always_comb begin
    match = ~(att_q ^ cmp);
    att_d = att_q;
    if (att_we) att_d = (att_q & ~match) | (wdata & match);
    att_d  = att_d | evt;
    att_en = att_we | (|evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      att_q <= RST_VAL;
      ntf_q <= '0;
    end else begin
      if (att_en) att_q <= att_d;
      if (ntf_we) ntf_q <= wdata;
    end
  end

  assign mar_bit = |(att_q & ntf_q);
endmodule

// File: rtl/attn_hier.sv
module attn_hier #(
  parameter int NREG = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mn_we,
  input  logic [NREG-1:0] mn_wdata,
  input  logic [NREG-1:0] mar,
  output logic [NREG-1:0] mn_q,
  output logic            irq_o
);
  logic irq_d;

  always_comb irq_d = |(mar & mn_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mn_q  <= '0;
      irq_o <= 1'b0;
    end else begin
      if (mn_we) mn_q <= mn_wdata;
      irq_o <= irq_d;
    end
  end
endmodule

// File: rtl/attn_irq_ctrl.sv
module attn_irq_ctrl #(
  parameter int DW   = attn_pkg::DW,
  parameter int NREG = attn_pkg::NREG,
  parameter int AW   = attn_pkg::AW,
  parameter int NOP  = attn_pkg::NOP
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [DW-1:0]      bus_wdata_i,
  output logic [DW-1:0]      bus_rdata_o,
  input  logic [NREG*DW-1:0] evt_set_i,
  output logic [NOP-1:0]     op_start_o,
  output logic               irq_o
);
  localparam int ADDR_MAR  = 0;
  localparam int ADDR_MNR  = 1;
  localparam int ADDR_ATT0 = 2;
  localparam int ADDR_CMP  = ADDR_ATT0 + NREG;
  localparam int ADDR_NTF0 = ADDR_CMP + 1;
  localparam int SVC       = attn_pkg::IDX_SVC;

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [NREG-1:0][DW-1:0] att_q;
  logic [NREG-1:0][DW-1:0] ntf_q;
  logic [NREG-1:0][DW-1:0] evt_v;
  logic [NREG-1:0]         att_we;
  logic [NREG-1:0]         ntf_we;
  logic [NREG-1:0]         mar;
  logic [NREG-1:0]         mn_q;
  logic                    mn_we;
  logic [DW-1:0]           cmp_q;
  logic [DW-1:0]           cmp_d;
  logic                    cmp_en;
  logic [DW-1:0]           rd_val;
  logic                    att_hit;
  logic [DW-1:0]           rdata_d;
  logic [NOP-1:0]          op_d;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_bank
      assign evt_v[g]  = evt_set_i[g*DW +: DW];
      assign att_we[g] = bus_wr_i && (bus_addr_i == AW'(ADDR_ATT0 + g));
      assign ntf_we[g] = bus_wr_i && (bus_addr_i == AW'(ADDR_NTF0 + g));

      attn_bank #(
        .DW      (DW),
        .RST_VAL (DW'(attn_pkg::att_rst_val(g, NOP)))
      ) u_bank (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .att_we  (att_we[g]),
        .ntf_we  (ntf_we[g]),
        .wdata   (bus_wdata_i),
        .cmp     (cmp_q),
        .evt     (evt_v[g]),
        .att_q   (att_q[g]),
        .ntf_q   (ntf_q[g]),
        .mar_bit (mar[g])
      );
    end
  endgenerate

  assign mn_we = bus_wr_i && (bus_addr_i == AW'(ADDR_MNR));

  attn_hier #(.NREG(NREG)) u_hier (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .mn_we    (mn_we),
    .mn_wdata (bus_wdata_i[NREG-1:0]),
    .mar      (mar),
    .mn_q     (mn_q),
    .irq_o    (irq_o)
  );

  // Read mux and compare-register capture
  always_comb begin
    rd_val  = '0;
    att_hit = 1'b0;
    if (bus_addr_i == AW'(ADDR_MAR)) rd_val = DW'(mar);
    if (bus_addr_i == AW'(ADDR_MNR)) rd_val = DW'(mn_q);
    if (bus_addr_i == AW'(ADDR_CMP)) rd_val = cmp_q;
    for (int i = 0; i < NREG; i++) begin
      if (bus_addr_i == AW'(ADDR_ATT0 + i)) begin
        rd_val  = att_q[i];
        att_hit = 1'b1;
      end
      if (bus_addr_i == AW'(ADDR_NTF0 + i)) rd_val = ntf_q[i];
    end
    cmp_en  = bus_rd_i && att_hit;
    cmp_d   = rd_val;
    rdata_d = bus_rd_i ? rd_val : '0;
  end

  // A completion bit cleared by a host write starts its operation
  always_comb begin
    op_d = {NOP{att_we[SVC]}} & att_q[SVC][NOP-1:0] & cmp_q[NOP-1:0]
         & ~bus_wdata_i[NOP-1:0] & ~evt_v[SVC][NOP-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmp_q       <= '0;
      bus_rdata_o <= '0;
      op_start_o  <= '0;
    end else begin
      if (cmp_en) cmp_q <= cmp_d;
      bus_rdata_o <= rdata_d;
      op_start_o  <= op_d;
    end
  end
endmodule

// File: rtl/attn_irq_ctrl_chk.sv
module attn_irq_ctrl_chk #(
  parameter int DW   = 8,
  parameter int NREG = 5,
  parameter int AW   = 4,
  parameter int NOP  = 2,
  parameter int SVC_ADDR = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [AW-1:0]      bus_addr,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [NREG*DW-1:0] evt,
  input logic [NREG*DW-1:0] att,
  input logic [DW-1:0]      cmp,
  input logic [NREG-1:0]    mar,
  input logic [NREG-1:0]    mn,
  input logic [NOP-1:0]     op_start,
  input logic               irq
);
  // R4
  evt_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((att & $past(evt)) == $past(evt)));

  // R3
  no_clear_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ((~att & $past(att)) == '0));

  // R2
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(cmp));

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(mar & mn))));

  // R8
  op_start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start != '0) |-> $past(bus_wr && (bus_addr == AW'(SVC_ADDR))));
endmodule

bind attn_irq_ctrl attn_irq_ctrl_chk #(
  .DW(DW), .NREG(NREG), .AW(AW), .NOP(NOP), .SVC_ADDR(ADDR_ATT0 + SVC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .bus_addr (bus_addr_i),
  .bus_wr   (bus_wr_i),
  .bus_rd   (bus_rd_i),
  .evt      (evt_set_i),
  .att      (att_q),
  .cmp      (cmp_q),
  .mar      (mar),
  .mn       (mn_q),
  .op_start (op_start_o),
  .irq      (irq_o)
);

// File: tb/attn_irq_ctrl_bench.sv
`timescale 1ns/1ps
module attn_irq_ctrl_bench;
  localparam int NREG = 5;
  localparam int DW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [39:0] evt = '0;
  logic [7:0]  rdata;
  logic [1:0]  op_start;
  logic        irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  attn_irq_ctrl u_attn_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .evt_set_i(evt), .op_start_o(op_start), .irq_o(irq)
  );

  // Bench model of the register file
  logic [7:0] m_att [NREG];
  logic [7:0] m_ntf [NREG];
  logic [4:0] m_mn;
  logic [7:0] m_cmp;

  function automatic logic [4:0] m_mar();
    logic [4:0] r;
    for (int i = 0; i < NREG; i++) r[i] = |(m_att[i] & m_ntf[i]);
    return r;
  endfunction

  function automatic logic [7:0] m_read(input logic [3:0] a);
    if (a == 0) return {3'b0, m_mar()};
    if (a == 1) return {3'b0, m_mn};
    if (a >= 2 && a <= 6) return m_att[a-2];
    if (a == 7) return m_cmp;
    if (a >= 8 && a <= 12) return m_ntf[a-8];
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, update model, check after the edge.
  task automatic step(input logic r, input logic w, input logic [3:0] a,
                      input logic [7:0] wd, input logic [39:0] ev);
    logic [7:0] e_rd;
    logic       e_irq;
    logic [1:0] e_op;
    logic [7:0] old_att [NREG];
    logic [7:0] mt;
    rd = r; wr = w; addr = a; wdata = wd; evt = ev;
    e_rd  = r ? m_read(a) : 8'h00;
    e_irq = |(m_mar() & m_mn);
    for (int i = 0; i < NREG; i++) old_att[i] = m_att[i];
    if (w) begin
      if (a == 1) m_mn = wd[4:0];
      if (a >= 2 && a <= 6) begin
        mt = ~(m_att[a-2] ^ m_cmp);
        m_att[a-2] = (m_att[a-2] & ~mt) | (wd & mt);
      end
      if (a >= 8 && a <= 12) m_ntf[a-8] = wd;
    end
    for (int i = 0; i < NREG; i++) m_att[i] = m_att[i] | ev[i*8 +: 8];
    e_op = (w && a == 4) ? (old_att[2][1:0] & ~m_att[2][1:0]) : 2'b00;
    if (r && a >= 2 && a <= 6) m_cmp = old_att[a-2];
    @(posedge clk);
    @(negedge clk);
    rd = 0; wr = 0; evt = '0;
    chk("R9 read data", rdata, e_rd);
    chk("R7 irq level", irq, e_irq);
    chk("R8 op_start", op_start, e_op);
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
    step(1, 0, a, 8'h00, '0);
    chk(req, rdata, exp);
  endtask

  function automatic logic [7:0] rst_exp(input int a);
    if (a == 2) return 8'h07;
    if (a == 4) return 8'h03;
    return 8'h00;
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NREG; i++) begin m_att[i] = 8'h00; m_ntf[i] = 8'h00; end
    m_att[0] = 8'h07; m_att[2] = 8'h03; m_mn = '0; m_cmp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq after reset", irq, 0);
    chk("R1 op_start after reset", op_start, 0);
    for (int a = 0; a < 16; a++) rd_chk(4'(a), rst_exp(a), "R1 reset value");

    // R2 compare loads on attention reads only
    rd_chk(4, 8'h03, "R2 read service");
    rd_chk(8, 8'h00, "R2 read notify");
    rd_chk(7, 8'h03, "R2 compare after notify read");

    // R5 notify read/write, master notify width
    step(0, 1, 9, 8'hA5, '0);
    rd_chk(9, 8'hA5, "R5 notify readback");
    step(0, 1, 1, 8'hFF, '0);
    rd_chk(1, 8'h1F, "R5 master notify width");
    step(0, 1, 1, 8'h00, '0);

    // R3 event between read and write survives; R8 start pulses
    rd_chk(4, 8'h03, "R3 read service");
    step(0, 0, 0, 8'h00, 40'h1 << (2*8 + 5));
    step(0, 1, 4, 8'h00, '0);
    chk("R8 both starts", op_start, 2'b11);
    rd_chk(4, 8'h20, "R3 late event kept");
    step(0, 1, 4, 8'h00, '0);
    chk("R8 no start when already clear", op_start, 2'b00);
    rd_chk(4, 8'h00, "R3 bit cleared after fresh read");
    step(0, 0, 0, 8'h00, 40'h1 << (2*8));
    rd_chk(4, 8'h01, "R4 completion event");
    // R8 event in same cycle as clearing write holds bit, no start
    step(0, 1, 4, 8'h00, 40'h1 << (2*8));
    chk("R8 held by event", op_start, 2'b00);

    // R4 event wins over same-cycle write
    step(0, 0, 0, 8'h00, 40'h1 << (3*8 + 4));
    rd_chk(5, 8'h10, "R4 request read");
    step(0, 1, 5, 8'h00, 40'h1 << (3*8 + 4));
    rd_chk(5, 8'h10, "R4 event priority");

    // R6 master attention derived and read-only
    step(0, 1, 0, 8'hFF, '0);
    rd_chk(0, 8'h00, "R6 master write ignored");
    step(0, 1, 7, 8'h5A, '0);
    rd_chk(7, 8'h10, "R6 compare write ignored");
    step(0, 1, 11, 8'h10, '0);
    rd_chk(0, 8'h08, "R6 master bit 3");

    // R7 irq lag through master notify
    chk("R7 irq masked", irq, 0);
    step(0, 1, 1, 8'h08, '0);
    chk("R7 irq one cycle late", irq, 0);
    step(0, 0, 0, 8'h00, '0);
    chk("R7 irq raised", irq, 1);
    step(0, 1, 1, 8'h00, '0);
    chk("R7 irq holds one cycle", irq, 1);
    step(0, 0, 0, 8'h00, '0);
    chk("R7 irq dropped", irq, 0);

    // R9 unmapped address
    rd_chk(15, 8'h00, "R9 unmapped");

    // Constrained random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [3:0] a;
      logic [39:0] ev;
      r  = int'($urandom % 10);
      a  = ($urandom % 4 == 0) ? 4'($urandom % 16) : 4'(2 + $urandom % 5);
      ev = ($urandom % 3 == 0) ? (40'h1 << ($urandom % 40)) : '0;
      if (r < 4)      step(1, 0, a, 8'h00, ev);
      else if (r < 8) step(0, 1, a, 8'($urandom), ev);
      else            step(1, 1, a, 8'($urandom), ev);
    end
    for (int a = 0; a < 16; a++) rd_chk(4'(a), m_read(4'(a)), "R6 final map sweep");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule